// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block stores the pad settings for one GPIO port of `NPINS` pins. Software sets them over a simple synchronous bus that has valid, write, address and data signals. The block drives the decoded settings straight to the pad ring. There are eight registers, each holding one bit per pin:

- three drive-strength selects (2 mA, 4 mA and 8 mA);
- open-drain enable;
- pull-up enable;
- pull-down enable;
- slew-rate control;
- digital-input enable.

Hardware keeps the drive-strength selection one-hot per pin. Writing a 1 to a pin's bit in any drive select register moves that pin to the chosen strength and clears the pin's bit in the other two drive registers in the same cycle. Writing a 0 to a drive bit leaves that pin alone, so no pin can end up with no strength selected. Each pin's strength also leaves the block as a 2-bit code.

A read request returns the addressed register on the cycle after it is accepted. The register bits sit in the low `NPINS` bits of the read data and the upper bits read as zero. Addresses that match no register read zero and ignore writes.

Top module: `pad_cfg_bank`

## Requirements
- R1: After reset:
  - the 2 mA select register holds all ones;
  - the 4 mA and 8 mA select registers hold zero;
  - the open-drain, pull-up, pull-down, slew and digital-enable registers hold zero;
  - every pin's drive code is 00.
- R2: Registers are addressed by byte address:
  - 0x500: 2 mA select
  - 0x504: 4 mA select
  - 0x508: 8 mA select
  - 0x50C: open-drain
  - 0x510: pull-up
  - 0x514: pull-down
  - 0x518: slew control
  - 0x51C: digital enable

  Bit i of each register belongs to pin i. A write takes data bits [NPINS-1:0]. A read returns the register in bits [NPINS-1:0] with all upper bits zero.
- R3: A write that sets bit i of a drive select register sets that bit and, in the same write, clears bit i of the other two drive select registers.
- R4: A data bit of 0 written to a drive select register leaves that pin's bits in all three drive registers unchanged.
- R5: A single drive select write with several data bits at 1 moves every one of those pins to that strength.
- R6: A write to one register leaves every other register unchanged. The only exception is the clearing described in R3.
- R7: Each pin's drive code on `pad_drive[2i+1:2i]` is 00 for 2 mA, 01 for 4 mA and 10 for 8 mA, and is never 11. The OR of the three drive select registers is all ones at all times.
- R8: The open-drain, pull-up, pull-down, slew and digital-enable outputs equal the contents of their registers, one bit per pin.
- R9: A read of an address that maps to no register returns zero. A write to such an address, including an address that is not word aligned, changes no register.
- R10: Read data is registered. A read accepted on one clock edge appears on `bus_rdata` after that edge and is held until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pad_drive | output | 2*NPINS | Per-pin drive code, pin i at bits [2i+1:2i] |
| pad_open_drain | output | NPINS | Per-pin open-drain enable |
| pad_pull_up | output | NPINS | Per-pin pull-up enable |
| pad_pull_down | output | NPINS | Per-pin pull-down enable |
| pad_slew_ctl | output | NPINS | Per-pin slew-rate control |
| pad_dig_en | output | NPINS | Per-pin digital-input enable |

## Verification
The drive-select logic is exercised with a sequence of writes that puts the three drive registers into overlapping states:

- single nibbles and alternating bit patterns, which separate per-pin clearing from whole-register clearing;
- an all-zero write, which shows that a 0 data bit really leaves the pin alone;
- an all-ones write, which moves every pin at once.

After each write, all three registers and every pin's drive code are compared with hand-computed values.

Further tests cover the attribute registers with distinct patterns, so a crossed address decode shows up as a wrong read-back. They also cover data in the upper bus bits, unmapped and misaligned addresses, and read data holding across idle cycles and writes.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;

    // Register offsets (byte addresses); drive registers come first
    localparam int unsigned REG_BASE  = 32'h500;
    localparam int unsigned REG_STEP  = 4;
    localparam int unsigned NUM_REGS  = 8;
    localparam int unsigned NUM_DRV   = 3;
    localparam int unsigned NUM_ATTR  = NUM_REGS - NUM_DRV;

    // Register index within the bank
    localparam int unsigned IDX_DRV2  = 0;
    localparam int unsigned IDX_DRV4  = 1;
    localparam int unsigned IDX_DRV8  = 2;
    localparam int unsigned IDX_OD    = 3;
    localparam int unsigned IDX_PU    = 4;
    localparam int unsigned IDX_PD    = 5;
    localparam int unsigned IDX_SLEW  = 6;
    localparam int unsigned IDX_DEN   = 7;

    typedef enum logic [1:0] {
        DRV_2MA = 2'b00,
        DRV_4MA = 2'b01,
        DRV_8MA = 2'b10
    } drv_code_e;

endpackage

// File: rtl/pad_attr_reg.sv
module pad_attr_reg #(
    parameter int unsigned     NPINS   = 8,
    parameter logic [NPINS-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] value
);

    typedef struct packed {
        logic [NPINS-1:0] bits;
    } attr_state_t;

    attr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.bits = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.bits <= RST_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign value = state_q.bits;

    // Without a write the register keeps its contents
    assert_attr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(value));

    // A write lands on the next cycle
    assert_attr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> value == $past(wdata));

endmodule

// File: rtl/pad_drive_sel.sv
module pad_drive_sel
    import pad_cfg_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   set_2ma,
    input  logic [NPINS-1:0]   set_4ma,
    input  logic [NPINS-1:0]   set_8ma,
    output logic [NPINS-1:0]   sel_2ma,
    output logic [NPINS-1:0]   sel_4ma,
    output logic [NPINS-1:0]   sel_8ma,
    output logic [2*NPINS-1:0] drv_code
);

    typedef struct packed {
        logic [NPINS-1:0] s2;
        logic [NPINS-1:0] s4;
        logic [NPINS-1:0] s8;
    } drv_state_t;

    drv_state_t state_d, state_q;

    // Setting a strength claims the pin; zeros change nothing
    always_comb begin
        state_d    = state_q;
        state_d.s2 = (state_q.s2 | set_2ma) & ~(set_4ma | set_8ma);
        state_d.s4 = (state_q.s4 | set_4ma) & ~(set_2ma | set_8ma);
        state_d.s8 = (state_q.s8 | set_8ma) & ~(set_2ma | set_4ma);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.s2 <= '1;
            state_q.s4 <= '0;
            state_q.s8 <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sel_2ma = state_q.s2;
    assign sel_4ma = state_q.s4;
    assign sel_8ma = state_q.s8;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        drv_code_e code;
        always_comb begin
            if (state_q.s8[i]) begin
                code = DRV_8MA;
            end else if (state_q.s4[i]) begin
                code = DRV_4MA;
            end else begin
                code = DRV_2MA;
            end
        end
        assign drv_code[2*i +: 2] = code;

        // Exactly one strength per pin
        assert_drv_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot({sel_2ma[i], sel_4ma[i], sel_8ma[i]}));

        assert_drv_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
            drv_code[2*i +: 2] != 2'b11);

        // No set bit for this pin: its strength is untouched
        assert_drv_zero_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(set_2ma[i] | set_4ma[i] | set_8ma[i])
                |=> $stable({sel_2ma[i], sel_4ma[i], sel_8ma[i]}));

        // Setting a strength clears the other two
        assert_drv_set4_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_4ma[i] |=> (sel_4ma[i] && !sel_2ma[i] && !sel_8ma[i]));

        assert_drv_set8_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_8ma[i] |=> (sel_8ma[i] && !sel_2ma[i] && !sel_4ma[i]));

        assert_drv_set2_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_2ma[i] |=> (sel_2ma[i] && drv_code[2*i +: 2] == 2'b00));
    end

endmodule

// File: rtl/pad_cfg_bank.sv
module pad_cfg_bank
    import pad_cfg_pkg::*;
#(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [2*NPINS-1:0] pad_drive,
    output logic [NPINS-1:0]   pad_open_drain,
    output logic [NPINS-1:0]   pad_pull_up,
    output logic [NPINS-1:0]   pad_pull_down,
    output logic [NPINS-1:0]   pad_slew_ctl,
    output logic [NPINS-1:0]   pad_dig_en
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t        state_d, state_q;
    logic [NUM_REGS-1:0] hit;
    logic             wr_en;
    logic             rd_en;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] reg_val [NUM_REGS];
    logic [DATA_W-1:0] rd_mux;
    logic             unused_wdata_hi;

    assign wr_en = bus_valid &  bus_write;
    assign rd_en = bus_valid & ~bus_write;
    assign wbits = bus_wdata[NPINS-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NPINS];

    // Full-address compare per register
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_BASE + REG_STEP * k);
        assign hit[k] = (bus_addr == OFS);
    end

    pad_drive_sel #(
        .NPINS (NPINS)
    ) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_2ma  (wbits & {NPINS{wr_en & hit[IDX_DRV2]}}),
        .set_4ma  (wbits & {NPINS{wr_en & hit[IDX_DRV4]}}),
        .set_8ma  (wbits & {NPINS{wr_en & hit[IDX_DRV8]}}),
        .sel_2ma  (reg_val[IDX_DRV2]),
        .sel_4ma  (reg_val[IDX_DRV4]),
        .sel_8ma  (reg_val[IDX_DRV8]),
        .drv_code (pad_drive)
    );

    for (genvar a = NUM_DRV; a < NUM_REGS; a++) begin : g_attr
        pad_attr_reg #(
            .NPINS   (NPINS),
            .RST_VAL ('0)
        ) u_attr (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en & hit[a]),
            .wdata (wbits),
            .value (reg_val[a])
        );
    end

    assign pad_open_drain = reg_val[IDX_OD];
    assign pad_pull_up    = reg_val[IDX_PU];
    assign pad_pull_down  = reg_val[IDX_PD];
    assign pad_slew_ctl   = reg_val[IDX_SLEW];
    assign pad_dig_en     = reg_val[IDX_DEN];

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (hit[k]) begin
                rd_mux[NPINS-1:0] = reg_val[k];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (rd_en) begin
            state_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata = state_q.rdata;

    // Unmapped reads return zero
    assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit == '0) |=> bus_rdata == '0);

    // Upper read bits are always zero
    assert_rdata_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NPINS] == '0);

    // Read data holds between accepted reads
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(bus_rdata));

    // The three drive registers together cover every pin
    assert_drive_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_val[IDX_DRV2] | reg_val[IDX_DRV4] | reg_val[IDX_DRV8]) == '1);

endmodule

// File: tb/sim_pad_cfg_bank.sv
module sim_pad_cfg_bank;

    localparam int NPINS  = 8;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_valid = 1'b0;
    logic               bus_write = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [DATA_W-1:0]  bus_wdata = '0;
    logic [DATA_W-1:0]  bus_rdata;
    logic [2*NPINS-1:0] pad_drive;
    logic [NPINS-1:0]   pad_open_drain, pad_pull_up, pad_pull_down, pad_slew_ctl, pad_dig_en;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pad_cfg_bank #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_drive(pad_drive), .pad_open_drain(pad_open_drain),
        .pad_pull_up(pad_pull_up), .pad_pull_down(pad_pull_down),
        .pad_slew_ctl(pad_slew_ctl), .pad_dig_en(pad_dig_en)
    );

    // Vector: {select 2b (0=2mA,1=4mA,2=8mA), data, exp 2mA, exp 4mA, exp 8mA}
    localparam logic [33:0] VEC [7] = '{
        {2'd1, 8'h0F, 8'hF0, 8'h0F, 8'h00},
        {2'd2, 8'h3C, 8'hC0, 8'h03, 8'h3C},
        {2'd0, 8'h00, 8'hC0, 8'h03, 8'h3C},
        {2'd0, 8'h81, 8'hC1, 8'h02, 8'h3C},
        {2'd1, 8'hFF, 8'h00, 8'hFF, 8'h00},
        {2'd2, 8'hAA, 8'h00, 8'h55, 8'hAA},
        {2'd0, 8'h0F, 8'h0F, 8'h50, 8'hA0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] exp_codes(input logic [7:0] m4, input logic [7:0] m8);
        logic [15:0] c = '0;
        for (int i = 0; i < 8; i++) begin
            c[2*i +: 2] = m8[i] ? 2'b10 : (m4[i] ? 2'b01 : 2'b00);
        end
        return c;
    endfunction

    task automatic check_drive(input string req, input logic [7:0] e2,
                               input logic [7:0] e4, input logic [7:0] e8);
        logic [DATA_W-1:0] r2, r4, r8;
        bus_rd(12'h500, r2);
        bus_rd(12'h504, r4);
        bus_rd(12'h508, r8);
        check(req, "2mA reg", r2, {24'h0, e2});
        check(req, "4mA reg", r4, {24'h0, e4});
        check(req, "8mA reg", r8, {24'h0, e8});
        check("R7", "drive OR all ones", {24'h0, r2[7:0] | r4[7:0] | r8[7:0]}, 32'h0000_00FF);
        check("R7", "pad_drive codes", {16'h0, pad_drive}, {16'h0, exp_codes(e4, e8)});
        for (int i = 0; i < NPINS; i++) begin
            check("R7", "code not 11", {31'h0, pad_drive[2*i +: 2] == 2'b11}, 32'h0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [DATA_W-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_drive("R1", 8'hFF, 8'h00, 8'h00);
        for (int k = 3; k < 8; k++) begin
            bus_rd(12'h500 + 12'(4 * k), rd);
            check("R1", "attr reg reset", rd, 32'h0);
        end
        check("R1", "attr outputs reset",
              {pad_open_drain, pad_pull_up, pad_pull_down, pad_slew_ctl}, 32'h0);
        check("R1", "den output reset", {24'h0, pad_dig_en}, 32'h0);

        // Drive-select vector walk: R3, R4, R5
        for (int v = 0; v < 7; v++) begin
            logic [1:0] sel;
            logic [7:0] dat, e2, e4, e8;
            {sel, dat, e2, e4, e8} = VEC[v];
            bus_wr(12'h500 + 12'(4 * sel), {24'h0, dat});
            check_drive("R3,R4,R5", e2, e4, e8);
        end

        // R8 / R2 attribute registers with distinct patterns
        bus_wr(12'h50C, 32'h0000_005A);
        bus_wr(12'h510, 32'h0000_0033);
        bus_wr(12'h514, 32'h0000_00C0);
        bus_wr(12'h518, 32'h0000_000F);
        bus_wr(12'h51C, 32'h0000_00FF);
        bus_rd(12'h50C, rd); check("R2", "open-drain readback", rd, 32'h5A);
        bus_rd(12'h510, rd); check("R2", "pull-up readback", rd, 32'h33);
        bus_rd(12'h514, rd); check("R2", "pull-down readback", rd, 32'hC0);
        bus_rd(12'h518, rd); check("R2", "slew readback", rd, 32'h0F);
        bus_rd(12'h51C, rd); check("R2", "den readback", rd, 32'hFF);
        check("R8", "open-drain out", {24'h0, pad_open_drain}, 32'h5A);
        check("R8", "pull-up out", {24'h0, pad_pull_up}, 32'h33);
        check("R8", "pull-down out", {24'h0, pad_pull_down}, 32'hC0);
        check("R8", "slew out", {24'h0, pad_slew_ctl}, 32'h0F);
        check("R8", "den out", {24'h0, pad_dig_en}, 32'hFF);

        // R6 one write leaves other registers alone
        bus_wr(12'h510, 32'h0000_0001);
        check("R6", "pull-up out after write", {24'h0, pad_pull_up}, 32'h01);
        check("R6", "open-drain untouched", {24'h0, pad_open_drain}, 32'h5A);
        check("R6", "pull-down untouched", {24'h0, pad_pull_down}, 32'hC0);
        check_drive("R6", 8'h0F, 8'h50, 8'hA0);

        // R2 upper write bits dropped, upper read bits zero
        bus_wr(12'h50C, 32'hFFFF_FF11);
        bus_rd(12'h50C, rd); check("R2", "upper bits ignored", rd, 32'h11);

        // R9 unmapped and misaligned addresses
        bus_wr(12'h520, 32'hFFFF_FFFF);
        bus_wr(12'h501, 32'h0000_00F0);
        bus_wr(12'h4FC, 32'h0000_00FF);
        bus_rd(12'h520, rd); check("R9", "unmapped read 0x520", rd, 32'h0);
        bus_rd(12'h501, rd); check("R9", "misaligned read 0x501", rd, 32'h0);
        check_drive("R9", 8'h0F, 8'h50, 8'hA0);
        check("R9", "attrs untouched",
              {pad_open_drain, pad_pull_up, pad_pull_down, pad_slew_ctl}, 32'h1101_C00F);

        // R10 read data held across idle cycles and writes
        bus_rd(12'h514, rd); check("R10", "read pull-down", rd, 32'hC0);
        repeat (3) @(negedge clk);
        check("R10", "held after idle", bus_rdata, 32'hC0);
        bus_wr(12'h514, 32'h0000_0007);
        check("R10", "held across write", bus_rdata, 32'hC0);
        bus_rd(12'h514, rd); check("R10", "new read value", rd, 32'h07);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule